// File: doc/BRIEF.md
# I2C Bus Condition Legality Monitor

This block watches the synchronized SDA and SCL lines of an I2C port and recognises every Start and Stop condition on the bus. For each one it reads a state vector from the byte engine (idle flag, role, direction, whether the last byte was acknowledged, and the bit index of the next bit) and decides whether the condition came at a permitted moment. Only two moments are permitted: the engine is idle, or the engine is a slave receiver that has acknowledged a byte and waits for bit zero of the next one.

A condition at any other moment sets a sticky bus error flag and pulses an interrupt at once. The flag stays set until the host clears it. The monitor also sends a reset request back to the engine. A slave is reset on every external condition: a Start sends it to address reception and a Stop sends it to idle. A master ignores correctly placed external conditions, but a misplaced one makes it release both lines and go idle. Conditions that the block drives itself as master are marked by the engine and never count as errors.

Top module: `i2c_cond_watch`

## Requirements
- R1: A Start is SDA going from 1 to 0 between two consecutive samples while SCL is 1 in both samples. It gives a one-cycle `start_pulse` in the cycle after the first rising clock edge that samples the low SDA.
- R2: A Stop is SDA going from 0 to 1 between two consecutive samples while SCL is 1 in both samples. It gives a one-cycle `stop_pulse` with the same timing as R1.
- R3: An SDA change while SCL is 0, or in the same sample in which SCL changes, gives no pulse, no error and no reset request.
- R4: A condition is legal when `eng_idle`=1, or when `eng_slave`=1, `eng_rx`=1, `eng_ack_ok`=1 and `eng_bitpos`=0. A legal condition leaves `bus_err` unchanged and gives no `err_irq`.
- R5: An external condition that is not legal sets `bus_err` and gives a one-cycle `err_irq` in the same cycle as its Start or Stop pulse.
- R6: `bus_err` is cleared only by `err_clr`=1, one cycle after the strobe is sampled. Later legal conditions do not clear it. If a new error and `err_clr` are sampled on the same edge, the error wins and `bus_err` stays 1.
- R7: With `eng_slave`=1, every external condition gives a one-cycle `eng_rst` in the pulse cycle. `eng_to_addr` is 1 with it for a Start and 0 for a Stop.
- R8: With `eng_slave`=0, a misplaced external condition gives `eng_rst`=1 with `eng_to_addr`=0 (release the bus and go idle). A legal condition in the master role gives no `eng_rst`.
- R9: When `own_cond`=1 on the sampling edge, the condition still produces its Start or Stop pulse but sets no error, raises no `err_irq` and gives no `eng_rst`.
- R10: While reset is held and after it is released with both lines high, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sda_s | input | 1 | Synchronized SDA level |
| scl_s | input | 1 | Synchronized SCL level |
| eng_idle | input | 1 | Byte engine is idle |
| eng_slave | input | 1 | 1 = slave role, 0 = master role |
| eng_rx | input | 1 | 1 = engine receives the current byte |
| eng_ack_ok | input | 1 | Last byte was acknowledged |
| eng_bitpos | input | BIT_W (4) | Index of the next bit in the byte, 0 = first |
| own_cond | input | 1 | The block itself drives the condition as master |
| err_clr | input | 1 | Host strobe that clears the bus error flag |
| start_pulse | output | 1 | One-cycle Start indication |
| stop_pulse | output | 1 | One-cycle Stop indication |
| bus_err | output | 1 | Sticky misplaced-condition flag |
| err_irq | output | 1 | One-cycle interrupt for each misplaced condition |
| eng_rst | output | 1 | One-cycle reset request to the byte engine |
| eng_to_addr | output | 1 | With `eng_rst`: 1 = go to address reception, 0 = go idle |

## Verification
Every result of a condition sits behind a single register stage. The pulses, `bus_err`, `err_irq`, `eng_rst` and `eng_to_addr` therefore all change on the first rising edge that samples the new SDA level. The bench changes SDA just after a falling edge and samples all of these at the next falling edge. It samples once more one cycle later to confirm that the pulses have dropped and that the flag has held. A clear strobe is also due one edge after it is sampled, and it is checked at the falling edge that follows. Engine state, `own_cond` and `err_clr` are set in the same cycle as the SDA change, so they are judged on the same edge as the condition.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

  typedef enum logic [1:0] {
    COND_NONE  = 2'd0,
    COND_START = 2'd1,
    COND_STOP  = 2'd2
  } cond_e;

  typedef struct packed {
    logic idle;
    logic slave;
    logic rx;
    logic ack_ok;
  } eng_flags_t;

endpackage

// File: rtl/i2c_mon_rstsync.sv
module i2c_mon_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_ni = sync_q[STAGES-1];

endmodule

// File: rtl/i2c_mon_cond_det.sv
module i2c_mon_cond_det
  import i2c_mon_pkg::*;
(
  input  logic  clk,
  input  logic  rst_ni,
  input  logic  sda_i,
  input  logic  scl_i,
  output cond_e cond_o,
  output logic  start_pulse_o,
  output logic  stop_pulse_o
);

  logic sda_q;
  logic scl_q;
  logic scl_held;
  logic start_d;
  logic stop_d;

  // SCL must be high in both the previous and the current sample
  always_comb begin
    scl_held = scl_q & scl_i;
    cond_o   = COND_NONE;
    if (scl_held && sda_q && !sda_i) begin
      cond_o = COND_START;
    end else if (scl_held && !sda_q && sda_i) begin
      cond_o = COND_STOP;
    end
  end

  always_comb begin
    start_d = (cond_o == COND_START);
    stop_d  = (cond_o == COND_STOP);
  end

  // line history resets to the idle-bus level so reset release makes no edge
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_q         <= 1'b1;
      scl_q         <= 1'b1;
      start_pulse_o <= 1'b0;
      stop_pulse_o  <= 1'b0;
    end else begin
      sda_q         <= sda_i;
      scl_q         <= scl_i;
      start_pulse_o <= start_d;
      stop_pulse_o  <= stop_d;
    end
  end

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_ni)
    !(start_pulse_o && stop_pulse_o));  // R1
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_ni)
    start_pulse_o |=> !start_pulse_o);  // R1
  AST_STOP_SINGLE: assert property (@(posedge clk) disable iff (!rst_ni)
    stop_pulse_o |=> !stop_pulse_o);  // R2

endmodule

// File: rtl/i2c_mon_judge.sv
module i2c_mon_judge
  import i2c_mon_pkg::*;
#(
  parameter int BIT_W = 4
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  cond_e            cond_i,
  input  eng_flags_t       flags_i,
  input  logic [BIT_W-1:0] bitpos_i,
  input  logic             own_i,
  output logic             misplaced_o,
  output logic             eng_rst_o,
  output logic             eng_to_addr_o
);

  logic legal;
  logic external;
  logic rst_d;
  logic addr_d;

  // permitted windows: idle, or slave receiver at bit zero after an ACK
  always_comb begin
    legal = flags_i.idle |
            (flags_i.slave & flags_i.rx & flags_i.ack_ok & (bitpos_i == '0));
  end

  always_comb begin
    external    = (cond_i != COND_NONE) & ~own_i;
    misplaced_o = external & ~legal;
    rst_d       = external & (flags_i.slave | ~legal);
    addr_d      = rst_d & flags_i.slave & (cond_i == COND_START);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      eng_rst_o     <= 1'b0;
      eng_to_addr_o <= 1'b0;
    end else begin
      eng_rst_o     <= rst_d;
      eng_to_addr_o <= addr_d;
    end
  end

  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_ni)
    (eng_rst_o && !rst_d) |=> !eng_rst_o);  // R7

endmodule

// File: rtl/i2c_mon_err_flag.sv
module i2c_mon_err_flag (
  input  logic clk,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic bus_err_o,
  output logic irq_o
);

  logic err_d;
  logic irq_d;

  // a hardware set outranks a host clear sampled on the same edge
  always_comb begin
    err_d = set_i | (bus_err_o & ~clr_i);
    irq_d = set_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_err_o <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      bus_err_o <= err_d;
      irq_o     <= irq_d;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_err_o && !clr_i) |=> bus_err_o);  // R6
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !bus_err_o);  // R6
  AST_IRQ_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_o |-> bus_err_o);  // R5

endmodule

// File: rtl/i2c_cond_watch.sv
module i2c_cond_watch
  import i2c_mon_pkg::*;
#(
  parameter int BYTE_BITS   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int BIT_W      = $clog2(BYTE_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_s,
  input  logic             eng_idle,
  input  logic             eng_slave,
  input  logic             eng_rx,
  input  logic             eng_ack_ok,
  input  logic [BIT_W-1:0] eng_bitpos,
  input  logic             own_cond,
  input  logic             err_clr,
  output logic             start_pulse,
  output logic             stop_pulse,
  output logic             bus_err,
  output logic             err_irq,
  output logic             eng_rst,
  output logic             eng_to_addr
);

  logic       rst_ni;
  cond_e      cond_now;
  eng_flags_t flags;
  logic       misplaced;

  always_comb begin
    flags.idle   = eng_idle;
    flags.slave  = eng_slave;
    flags.rx     = eng_rx;
    flags.ack_ok = eng_ack_ok;
  end

  i2c_mon_rstsync #(.STAGES(SYNC_STAGES)) u_rstsync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  i2c_mon_cond_det u_det (
    .clk           (clk),
    .rst_ni        (rst_ni),
    .sda_i         (sda_s),
    .scl_i         (scl_s),
    .cond_o        (cond_now),
    .start_pulse_o (start_pulse),
    .stop_pulse_o  (stop_pulse)
  );

  i2c_mon_judge #(.BIT_W(BIT_W)) u_judge (
    .clk           (clk),
    .rst_ni        (rst_ni),
    .cond_i        (cond_now),
    .flags_i       (flags),
    .bitpos_i      (eng_bitpos),
    .own_i         (own_cond),
    .misplaced_o   (misplaced),
    .eng_rst_o     (eng_rst),
    .eng_to_addr_o (eng_to_addr)
  );

  i2c_mon_err_flag u_flag (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .set_i     (misplaced),
    .clr_i     (err_clr),
    .bus_err_o (bus_err),
    .irq_o     (err_irq)
  );

  AST_IRQ_ON_COND: assert property (@(posedge clk) disable iff (!rst_ni)
    err_irq |-> (start_pulse || stop_pulse));  // R5
  AST_RST_ON_COND: assert property (@(posedge clk) disable iff (!rst_ni)
    eng_rst |-> (start_pulse || stop_pulse));  // R7
  AST_ADDR_ON_START: assert property (@(posedge clk) disable iff (!rst_ni)
    eng_to_addr |-> (start_pulse && eng_rst));  // R7
  AST_OWN_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
    own_cond |=> (!err_irq && !eng_rst));  // R9

endmodule

// File: tb/i2c_cond_watch_bench.sv
module i2c_cond_watch_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sda_s, scl_s;
  logic       eng_idle, eng_slave, eng_rx, eng_ack_ok;
  logic [3:0] eng_bitpos;
  logic       own_cond, err_clr;
  logic       start_pulse, stop_pulse, bus_err, err_irq, eng_rst, eng_to_addr;

  int n_cmp = 0;
  int n_bad = 0;
  logic model_err = 1'b0;

  always #5 clk = ~clk;

  i2c_cond_watch u_i2c_cond_watch (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_s(scl_s),
    .eng_idle(eng_idle), .eng_slave(eng_slave), .eng_rx(eng_rx),
    .eng_ack_ok(eng_ack_ok), .eng_bitpos(eng_bitpos),
    .own_cond(own_cond), .err_clr(err_clr),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse), .bus_err(bus_err),
    .err_irq(err_irq), .eng_rst(eng_rst), .eng_to_addr(eng_to_addr)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic set_eng(input logic idle, input logic slave, input logic rx,
                         input logic ack, input logic [3:0] pos);
    eng_idle = idle; eng_slave = slave; eng_rx = rx; eng_ack_ok = ack; eng_bitpos = pos;
  endtask

  // bring SDA to pre_sda without creating a condition, ending with SCL high
  task automatic prep_lines(input logic pre_sda);
    @(negedge clk) scl_s = 1'b0;
    @(negedge clk) sda_s = pre_sda;
    @(negedge clk) scl_s = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_cond(input string req, input logic is_start, input logic own,
                          input logic clr_with);
    logic legal, x_irq, x_rst, x_addr;
    legal  = eng_idle | (eng_slave & eng_rx & eng_ack_ok & (eng_bitpos == 4'd0));
    x_irq  = !own & !legal;
    x_rst  = !own & (eng_slave | !legal);
    x_addr = x_rst & eng_slave & is_start;
    prep_lines(is_start ? 1'b1 : 1'b0);
    own_cond = own;
    err_clr  = clr_with;
    sda_s    = is_start ? 1'b0 : 1'b1;
    model_err = x_irq | (model_err & !clr_with);
    @(negedge clk);
    chk(req, "start_pulse", start_pulse, is_start);
    chk(req, "stop_pulse", stop_pulse, !is_start);
    chk(req, "err_irq", err_irq, x_irq);
    chk(req, "bus_err", bus_err, model_err);
    chk(req, "eng_rst", eng_rst, x_rst);
    chk(req, "eng_to_addr", eng_to_addr, x_addr);
    own_cond = 1'b0;
    err_clr  = 1'b0;
    @(negedge clk);
    chk(req, "start_pulse drop", start_pulse, 1'b0);
    chk(req, "stop_pulse drop", stop_pulse, 1'b0);
    chk(req, "err_irq drop", err_irq, 1'b0);
    chk(req, "eng_rst drop", eng_rst, 1'b0);
    chk(req, "bus_err hold", bus_err, model_err);
  endtask

  task automatic host_clear();
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
    model_err = 1'b0;
    chk("R6", "bus_err after clear", bus_err, 1'b0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", "start_pulse in reset", start_pulse, 1'b0);
    chk("R10", "bus_err in reset", bus_err, 1'b0);
    chk("R10", "eng_rst in reset", eng_rst, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10", "start_pulse after release", start_pulse, 1'b0);
    chk("R10", "stop_pulse after release", stop_pulse, 1'b0);
    chk("R10", "err_irq after release", err_irq, 1'b0);
    chk("R10", "bus_err after release", bus_err, 1'b0);
    chk("R10", "eng_to_addr after release", eng_to_addr, 1'b0);
  endtask

  task automatic t_legal();
    set_eng(1, 1, 0, 0, 4'd5);
    run_cond("R1 R4 R7 idle slave start", 1'b1, 1'b0, 1'b0);
    run_cond("R2 R7 idle slave stop", 1'b0, 1'b0, 1'b0);
    set_eng(1, 0, 0, 0, 4'd3);
    run_cond("R2 R8 idle master stop", 1'b0, 1'b0, 1'b0);
    set_eng(0, 1, 1, 1, 4'd0);
    run_cond("R4 R7 slave window start", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_misplaced();
    set_eng(0, 0, 0, 0, 4'd3);
    run_cond("R5 R8 busy master start", 1'b1, 1'b0, 1'b0);
    set_eng(0, 1, 1, 1, 4'd1);
    run_cond("R5 R7 slave bitpos nonzero stop", 1'b0, 1'b0, 1'b0);
    set_eng(0, 1, 0, 1, 4'd0);
    run_cond("R5 R7 slave transmitter start", 1'b1, 1'b0, 1'b0);
    set_eng(0, 1, 1, 0, 4'd0);
    run_cond("R5 slave after NACK stop", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_sticky();
    set_eng(1, 0, 0, 0, 4'd0);
    run_cond("R6 legal does not clear", 1'b1, 1'b0, 1'b0);
    chk("R6", "bus_err still set", bus_err, 1'b1);
    host_clear();
    set_eng(0, 0, 0, 0, 4'd2);
    run_cond("R6 set beats clear", 1'b0, 1'b0, 1'b1);
    chk("R6", "bus_err after collision", bus_err, 1'b1);
    host_clear();
  endtask

  task automatic t_noncond();
    set_eng(0, 0, 0, 0, 4'd4);
    prep_lines(1'b1);
    scl_s = 1'b0; sda_s = 1'b0;
    @(negedge clk);
    chk("R3", "start with SCL falling", start_pulse, 1'b0);
    chk("R3", "irq with SCL falling", err_irq, 1'b0);
    sda_s = 1'b1;
    @(negedge clk);
    chk("R3", "stop with SCL low", stop_pulse, 1'b0);
    chk("R3", "eng_rst with SCL low", eng_rst, 1'b0);
    scl_s = 1'b1; sda_s = 1'b0;
    @(negedge clk);
    chk("R3", "start with SCL rising", start_pulse, 1'b0);
    chk("R3", "bus_err unchanged", bus_err, 1'b0);
  endtask

  task automatic t_own();
    set_eng(0, 0, 0, 0, 4'd6);
    run_cond("R9 own start", 1'b1, 1'b1, 1'b0);
    run_cond("R9 own stop", 1'b0, 1'b1, 1'b0);
  endtask

  initial begin
    sda_s = 1'b1; scl_s = 1'b1; own_cond = 1'b0; err_clr = 1'b0;
    set_eng(1, 0, 0, 0, 4'd0);
    t_reset();
    t_legal();
    t_noncond();
    t_misplaced();
    t_sticky();
    t_own();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule